// File: doc/BRIEF.md
# Display Controller Status and Interrupt Register

This block keeps the error and event status of a display controller and raises one interrupt request line. Short hardware pulses set sticky status bits: overrun and underrun on the input-side FIFO, overrun and underrun on the output-side FIFO, the bias-transition counter reaching its programmed count, and a DMA bus error. Each sticky bit stays set until software writes a 1 to it. Two read-only flags follow hardware levels directly: "controller is off" and "DMA base address may be reloaded". Software cannot write these flags.

Software reaches the block over a simple register port with an address, a write strobe, write data and combinational read data. The status word is at address 0 and the interrupt enable mask is at address 1. The interrupt output is a level. It stays high while any set bit or flag has its enable set. It drops as soon as the last such bit is cleared, or as soon as its flag falls.

Top module: `stat_sticky_irq`

## Requirements
- R1: A one-cycle pulse on `ev_pulse[i]` sets sticky bit i from the next clock edge. The bit stays set through any number of later cycles with no clear.
- R2: A write to address 0 with `wr_data[i]`=1, for i in 0..5, clears sticky bit i at that clock edge.
- R3: Writing 0 to a sticky bit position at address 0 leaves that bit unchanged.
- R4: Read bits 7:6 of address 0 show `cond_lvl[1:0]` in the same cycle. Writing to bits 7:6 has no effect.
- R5: A set pulse and a write-1 clear on the same bit in the same cycle leave the bit set.
- R6: `irq_o` is 1 exactly when some bit of the status byte {cond_lvl, sticky} has its matching enable bit set. It returns to 0 once no enabled bit remains set.
- R7: The enable mask at address 1 is 8 bits wide. Bit i gates status bit i. A write stores `wr_data[7:0]`, and a read returns the mask in bits 7:0.
- R8: Pulling `rst_n` low clears all sticky bits and sets the mask to all ones at once, without waiting for a clock edge.
- R9: Reads change no state. Unmapped addresses (2 and above) read 0, and writes to them are ignored. Unused read bits 31:8 are 0.

The sticky bit order at address 0 is:
- bit 0: input FIFO overrun
- bit 1: input FIFO underrun
- bit 2: output FIFO overrun
- bit 3: output FIFO underrun
- bit 4: bias count reached
- bit 5: DMA bus error

The flags are bit 6, controller off, and bit 7, base reload ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| ev_pulse | input | 6 | Hardware event pulses that set sticky bits |
| cond_lvl | input | 2 | Hardware condition levels shown as read-only flags |
| irq_o | output | 1 | Level interrupt request |

## Verification
Single events are pulsed one at a time and read back, which separates the set path from the hold path and shows each bit position. All-zero writes, single-bit write-1 clears and same-cycle set/clear collisions then tell apart write-0 behaviour, write-1 behaviour and set priority. The flags are toggled while 1s are written over them, and the mask is walked through single-bit patterns, which shows whether the interrupt follows the gated level of each source. A long random mix of events, writes, addresses and flags, with a mid-run asynchronous reset, is compared cycle by cycle against a behavioural model.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned REG_STAT = 0;
  localparam int unsigned REG_MASK = 1;

  typedef enum logic [1:0] {
    RD_STAT = 2'd0,
    RD_MASK = 2'd1,
    RD_NONE = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/stat_reg_decode.sv
module stat_reg_decode
  import stat_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  output logic          stat_we,
  output logic          mask_we,
  output rd_sel_e       rd_sel
);
  localparam logic [AW-1:0] A_STAT = AW'(REG_STAT);
  localparam logic [AW-1:0] A_MASK = AW'(REG_MASK);

  logic hit_stat;
  logic hit_mask;

  always_comb begin
    hit_stat = (addr == A_STAT);
    hit_mask = (addr == A_MASK);
    stat_we  = wr_en & hit_stat;
    mask_we  = wr_en & hit_mask;
    if (hit_stat)      rd_sel = RD_STAT;
    else if (hit_mask) rd_sel = RD_MASK;
    else               rd_sel = RD_NONE;
  end
endmodule

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_ok_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    logic en;

    always_comb begin
      en  = set_i[i] | clr_i[i];
      nxt = set_i[i] | (q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_ok_n) begin
      if (!rst_ok_n) q[i] <= 1'b0;
      else if (en)   q[i] <= nxt;
    end
  end
endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_ok_n,
  input  logic         we,
  input  logic [N-1:0] wd,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;

  always_comb nxt = wd;

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) q <= '1;
    else if (we)   q <= nxt;
  end
endmodule

// File: rtl/stat_irq_or.sv
module stat_irq_or #(
  parameter int N = 8
) (
  input  logic [N-1:0] src,
  input  logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] gated;

  always_comb begin
    gated = src & en;
    irq   = |gated;
  end
endmodule

// File: rtl/stat_sticky_irq.sv
module stat_sticky_irq
  import stat_pkg::*;
#(
  parameter int N_EVT = 6,
  parameter int N_FLG = 2,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [N_EVT-1:0] ev_pulse,
  input  logic [N_FLG-1:0] cond_lvl,
  output logic             irq_o
);
  localparam int NB = N_EVT + N_FLG;

  logic             rst_ok_n;
  logic             stat_we;
  logic             mask_we;
  rd_sel_e          rd_sel;
  logic [N_EVT-1:0] clr_vec;
  logic [N_EVT-1:0] sticky_q;
  logic [NB-1:0]    mask_q;
  logic [NB-1:0]    stat_word;

  stat_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n)
  );

  stat_reg_decode #(.AW(AW)) u_dec (
    .addr(addr), .wr_en(wr_en), .stat_we(stat_we), .mask_we(mask_we), .rd_sel(rd_sel)
  );

  always_comb clr_vec = stat_we ? wr_data[N_EVT-1:0] : '0;

  stat_sticky_bank #(.N(N_EVT)) u_bank (
    .clk(clk), .rst_ok_n(rst_ok_n), .set_i(ev_pulse), .clr_i(clr_vec), .q(sticky_q)
  );

  stat_mask_reg #(.N(NB)) u_mask (
    .clk(clk), .rst_ok_n(rst_ok_n), .we(mask_we), .wd(wr_data[NB-1:0]), .q(mask_q)
  );

  always_comb stat_word = {cond_lvl, sticky_q};

  stat_irq_or #(.N(NB)) u_irq (
    .src(stat_word), .en(mask_q), .irq(irq_o)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      RD_STAT: rd_data[NB-1:0] = stat_word;
      RD_MASK: rd_data[NB-1:0] = mask_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/stat_sticky_irq_chk.sv
module stat_sticky_irq_chk
  import stat_pkg::*;
#(
  parameter int N_EVT = 6,
  parameter int N_FLG = 2,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input logic                   clk,
  input logic                   rst_ok_n,
  input logic [AW-1:0]          addr,
  input logic                   wr_en,
  input logic [DW-1:0]          wr_data,
  input logic [N_EVT-1:0]       ev_pulse,
  input logic [N_FLG-1:0]       cond_lvl,
  input logic                   irq_o,
  input logic [N_EVT-1:0]       sticky_q,
  input logic [N_EVT+N_FLG-1:0] mask_q
);
  localparam int NB = N_EVT + N_FLG;

  logic [N_EVT-1:0] clr_req;
  always_comb clr_req = (wr_en && addr == AW'(REG_STAT)) ? wr_data[N_EVT-1:0] : '0;

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ev_pulse != '0) |=> ((sticky_q & $past(ev_pulse)) == $past(ev_pulse)));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((clr_req & ~ev_pulse) != '0) |=> ((sticky_q & $past(clr_req & ~ev_pulse)) == '0));

  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (sticky_q != '0) |=> ((sticky_q & $past(sticky_q & ~clr_req)) == $past(sticky_q & ~clr_req)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((clr_req & ev_pulse) != '0) |=> ((sticky_q & $past(clr_req & ev_pulse)) == $past(clr_req & ev_pulse)));

  p_irq_on_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (({cond_lvl, sticky_q} & mask_q) != '0) |-> irq_o);

  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (sticky_q == '0 && cond_lvl == '0) |-> !irq_o);

  p_mask_wr_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && addr == AW'(REG_MASK)) |=> (mask_q == $past(wr_data[NB-1:0])));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (addr != AW'(REG_MASK)) |=> $stable(mask_q));
endmodule

bind stat_sticky_irq stat_sticky_irq_chk #(
  .N_EVT(N_EVT), .N_FLG(N_FLG), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_ok_n(rst_ok_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .ev_pulse(ev_pulse), .cond_lvl(cond_lvl), .irq_o(irq_o),
  .sticky_q(sticky_q), .mask_q(mask_q)
);

// File: tb/sim_stat_sticky_irq.sv
`timescale 1ns/1ps
module sim_stat_sticky_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  ev_pulse = '0;
  logic [1:0]  cond_lvl = '0;
  logic        irq_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string req = "R8";

  logic [5:0] m_st = '0;
  logic [7:0] m_mask = 8'hFF;

  always #2 clk = ~clk;

  stat_sticky_irq u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ev_pulse(ev_pulse), .cond_lvl(cond_lvl), .irq_o(irq_o)
  );

  // Behavioural model: sticky set has priority over a write-1 clear (R5).
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st   = '0;
      m_mask = 8'hFF;
    end else begin
      logic [5:0] clr;
      clr = (wr_en && addr == 4'd0) ? wr_data[5:0] : 6'd0;
      m_st = (m_st & ~clr) | ev_pulse;
      if (wr_en && addr == 4'd1) m_mask = wr_data[7:0];
    end
  end

  function automatic logic [31:0] exp_rd();
    if (addr == 4'd0)      return {24'd0, cond_lvl, m_st};
    else if (addr == 4'd1) return {24'd0, m_mask};
    else                   return 32'd0;
  endfunction

  always @(negedge clk) begin
    logic [31:0] e;
    logic        ei;
    cycles++;
    e  = exp_rd();
    ei = |({cond_lvl, m_st} & m_mask);
    n_cmp++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s rd_data addr=%0d actual=%h expected=%h", req, addr, rd_data, e);
    end
    n_cmp++;
    if (irq_o !== ei) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", req, irq_o, ei);
    end
  end

  task automatic drive(input logic [5:0] ev, input logic [1:0] fl,
                       input logic we, input logic [3:0] a, input logic [31:0] wd);
    @(posedge clk);
    #1;
    ev_pulse = ev; cond_lvl = fl; wr_en = we; addr = a; wr_data = wd;
  endtask

  task automatic idle(input int n, input logic [3:0] a);
    for (int k = 0; k < n; k++) drive('0, cond_lvl, 1'b0, a, '0);
  endtask

  initial begin
    // R8: reset state
    req = "R8";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4, 4'd0);
    idle(2, 4'd1);
    // R1: each event alone, held afterwards
    req = "R1";
    for (int i = 0; i < 6; i++) begin
      drive(6'(1 << i), 2'b00, 1'b0, 4'd0, '0);
      idle(3, 4'd0);
    end
    // R3: writing zeros keeps bits
    req = "R3";
    drive('0, 2'b00, 1'b1, 4'd0, 32'h0);
    drive('0, 2'b00, 1'b1, 4'd0, 32'hFFFF_FF00);
    idle(2, 4'd0);
    // R2: write-1 clears one bit at a time
    req = "R2";
    for (int i = 0; i < 6; i++) begin
      drive('0, 2'b00, 1'b1, 4'd0, 32'(1 << i));
      idle(1, 4'd0);
    end
    // R5: set and clear collide
    req = "R5";
    drive(6'b000101, 2'b00, 1'b1, 4'd0, 32'h3F);
    idle(2, 4'd0);
    drive(6'b100000, 2'b00, 1'b1, 4'd0, 32'h25);
    idle(2, 4'd0);
    // R4: flags follow levels, writes ignored
    req = "R4";
    drive('0, 2'b01, 1'b0, 4'd0, '0);
    drive('0, 2'b10, 1'b1, 4'd0, 32'hC0);
    drive('0, 2'b11, 1'b1, 4'd0, 32'hFF);
    drive('0, 2'b00, 1'b0, 4'd0, '0);
    // R7 / R6: mask walking and gated interrupt
    req = "R7";
    drive(6'b001000, 2'b00, 1'b1, 4'd1, 32'h0);
    idle(2, 4'd1);
    for (int i = 0; i < 8; i++) begin
      drive('0, 2'b10, 1'b1, 4'd1, 32'(1 << i));
      idle(1, 4'd0);
    end
    req = "R6";
    drive('0, 2'b00, 1'b1, 4'd1, 32'hFF);
    drive('0, 2'b00, 1'b1, 4'd0, 32'h3F);
    idle(2, 4'd0);
    drive('0, 2'b01, 1'b0, 4'd0, '0);
    drive('0, 2'b00, 1'b0, 4'd0, '0);
    // R9: unmapped addresses and repeated reads
    req = "R9";
    drive(6'b010000, 2'b00, 1'b0, 4'd0, '0);
    for (int a = 2; a < 16; a++) drive('0, 2'b11, 1'b1, 4'(a), 32'hFFFF_FFFF);
    idle(5, 4'd0);
    idle(2, 4'd1);
    // R6: random mix
    req = "R6";
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] ev;
      ev = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
      drive(ev, 2'($urandom), ($urandom_range(0, 2) == 0), 4'($urandom_range(0, 3)), $urandom);
    end
    // R8: asynchronous reset mid-run
    req = "R8";
    drive(6'h3F, 2'b00, 1'b1, 4'd1, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b0; ev_pulse = '0; wr_en = 1'b0; addr = 4'd0;
    @(posedge clk); #1 addr = 4'd1;
    @(posedge clk); #1 rst_n = 1'b1;
    idle(4, 4'd0);
    idle(2, 4'd1);
    @(negedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<20000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule